// File: doc/BRIEF.md
# DRAM Warm-up and CAS-before-RAS Refresh Sequencer

This block owns the row and column strobes of an asynchronous fast-page-mode DRAM during every operation that does not move data. After reset it keeps both strobes inactive for a long settling pause. It then runs a burst of eight CAS-before-RAS cycles so that the memory's internal row counter and sense circuits come alive, and only after that does it tell the host that the memory may be used. From then on it answers single-cycle refresh requests with CAS-before-RAS cycles. A level request puts the memory into self refresh, where the row strobe is held low for a long time. A pulse on the stale input signals that the memory has gone without strobe activity for too long, and it triggers a fresh warm-up burst.

All timing minimums are given in nanoseconds and turned into whole clock counts, rounded up, from a clock-period parameter. The write enable strobe is tied inactive. A host arbiter looks at `busy` to learn when the strobes belong to this block and at `ready` to learn when the memory has been initialised.

Top module: `cbr_refresh_seq`

## Requirements
- R1: While reset is high, and for at least PAUSE_NS after reset falls, ras_n and cas_n stay high, ready is 0 and busy is 0.
- R2: After the pause, exactly WARM_CYCLES (default 8) CAS-before-RAS cycles take place before ready first goes to 1, and busy is 0 when ready rises.
- R3: In every CAS-before-RAS cycle, cas_n is low for at least CSR_NS before ras_n falls, and ras_n never falls while cas_n is high.
- R4: In an ordinary refresh cycle, ras_n stays low for at least RAS_NS and at least CHR_NS, and ras_n and cas_n return high in the same clock cycle.
- R5: Between two consecutive ordinary cycles, both strobes are high for at least RP_NS before cas_n falls again.
- R6: A one-cycle pulse on refresh_req is remembered. One received while the block is idle gets its own cycle. Any number received while a cycle is under way are merged into one follow-up cycle. One arriving in the clock where a remembered request is taken earns a further cycle.
- R7: While sref_req is 1 at an idle point, the block enters self refresh: cas_n falls first, as in R3, and ras_n stays low for at least RASS_NS and for as long as sref_req stays 1, even if sref_req is released early.
- R8: On self-refresh exit, cas_n stays low for at least CHS_NS after ras_n rises, and ras_n stays high for at least RPS_NS before it next falls.
- R9: When sref_req and a remembered refresh request are both present at an idle point, self refresh runs first and the refresh cycle follows. A sequence already under way is never cut short.
- R10: A pulse on stale_ind drives ready to 0 from the next cycle. A new burst of WARM_CYCLES CAS-before-RAS cycles then runs, and ready returns to 1 when that burst ends.
- R11: busy is 1 whenever ras_n or cas_n is low, and it stays 1 through each closing precharge period. It is 0 when the block is idle.
- R12: we_n is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refresh_req | input | 1 | One-cycle pulse asking for a CAS-before-RAS refresh |
| sref_req | input | 1 | Level: 1 asks for self refresh, 0 asks to leave it |
| stale_ind | input | 1 | Pulse: the memory has gone unstrobed too long and needs a new warm-up |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, held high |
| ready | output | 1 | Memory is initialised and usable |
| busy | output | 1 | The strobes are owned by a sequence in progress |

## Verification
An ordinary refresh request and a self-refresh request can reach the idle decision in the same clock, so that two different strobe sequences compete for the same start. The bench raises refresh_req and sref_req on the same edge. It then watches which sequence shows up on the strobes: a self-refresh period has cas_n still low when ras_n rises, while an ordinary cycle releases both strobes together. The bench requires the self-refresh period to come first with no refresh cycle before it, and then exactly one refresh cycle after it. A second case starts a refresh cycle first and raises sref_req while that cycle is under way, and it checks that the cycle finishes before self refresh starts.

// File: rtl/cbr_seq_pkg.sv
`timescale 1ns/1ps
package cbr_seq_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_CSR,
        ST_RLOW,
        ST_PRE,
        ST_SR_CSR,
        ST_SR_HOLD,
        ST_SR_CHS,
        ST_SR_PRE
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic busy;
    } strobe_t;

    // Whole clock cycles covering a duration in ns, never less than one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobe_of(input seq_state_e s);
        strobe_t o;
        o = '{ras_n: 1'b1, cas_n: 1'b1, busy: 1'b0};
        case (s)
            ST_CSR, ST_SR_CSR, ST_SR_CHS: o = '{ras_n: 1'b1, cas_n: 1'b0, busy: 1'b1};
            ST_RLOW, ST_SR_HOLD:          o = '{ras_n: 1'b0, cas_n: 1'b0, busy: 1'b1};
            ST_PRE, ST_SR_PRE:            o = '{ras_n: 1'b1, cas_n: 1'b1, busy: 1'b1};
            default:                      o = '{ras_n: 1'b1, cas_n: 1'b1, busy: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/seq_timer.sv
`timescale 1ns/1ps
module seq_timer #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= RST_VAL;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_flag.sv
`timescale 1ns/1ps
module seq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    logic q_r;

    // A set in the same cycle as a clear wins: that request is a new one.
    always_ff @(posedge clk) begin
        if (rst) q_r <= 1'b0;
        else     q_r <= (q_r & ~clr) | set;
    end

    assign q = q_r;
endmodule

// File: rtl/cbr_refresh_seq.sv
`timescale 1ns/1ps
module cbr_refresh_seq
    import cbr_seq_pkg::*;
#(
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned PAUSE_NS    = 200000,
    parameter int unsigned CSR_NS      = 10,
    parameter int unsigned CHR_NS      = 10,
    parameter int unsigned RAS_NS      = 60,
    parameter int unsigned RP_NS       = 40,
    parameter int unsigned RASS_NS     = 100000,
    parameter int unsigned RPS_NS      = 85,
    parameter int unsigned CHS_NS      = 30,
    parameter int unsigned WARM_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic refresh_req,
    input  logic sref_req,
    input  logic stale_ind,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic ready,
    output logic busy
);
    localparam int unsigned C_PAUSE = ns_to_cyc(PAUSE_NS, CLK_NS);
    localparam int unsigned C_CSR   = ns_to_cyc(CSR_NS, CLK_NS);
    localparam int unsigned C_LOW   = max2(ns_to_cyc(RAS_NS, CLK_NS), ns_to_cyc(CHR_NS, CLK_NS));
    localparam int unsigned C_RP    = ns_to_cyc(RP_NS, CLK_NS);
    localparam int unsigned C_RASS  = ns_to_cyc(RASS_NS, CLK_NS);
    localparam int unsigned C_RPS   = ns_to_cyc(RPS_NS, CLK_NS);
    localparam int unsigned C_CHS   = ns_to_cyc(CHS_NS, CLK_NS);
    localparam int unsigned C_MAX   = max2(max2(C_PAUSE, C_RASS),
                                      max2(max2(C_CSR, C_LOW), max2(C_RP, max2(C_RPS, C_CHS))));
    localparam int unsigned TW      = $clog2(C_MAX + 1);
    localparam int unsigned WW      = $clog2(WARM_CYCLES + 1);

    localparam logic [TW-1:0] L_PAUSE = TW'(C_PAUSE - 1);
    localparam logic [TW-1:0] L_CSR   = TW'(C_CSR - 1);
    localparam logic [TW-1:0] L_LOW   = TW'(C_LOW - 1);
    localparam logic [TW-1:0] L_RP    = TW'(C_RP - 1);
    localparam logic [TW-1:0] L_RASS  = TW'(C_RASS - 1);
    localparam logic [TW-1:0] L_RPS   = TW'(C_RPS - 1);
    localparam logic [TW-1:0] L_CHS   = TW'(C_CHS - 1);
    localparam logic [WW-1:0] W_FULL  = WW'(WARM_CYCLES);
    localparam logic [WW-1:0] W_ONE   = WW'(1);

    seq_state_e     state_q, state_d;
    strobe_t        strb_q;
    logic [WW-1:0]  warm_q, warm_d;
    logic           in_warm_q, in_warm_d;
    logic           init_q, init_d;
    logic           t_load, t_zero;
    logic [TW-1:0]  t_val;
    logic           ref_pend, stale_pend, ref_take, stale_take;

    seq_timer #(.W(TW), .RST_VAL(L_PAUSE)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    seq_flag u_ref_flag (
        .clk(clk), .rst(rst), .set(refresh_req), .clr(ref_take), .q(ref_pend)
    );

    seq_flag u_stale_flag (
        .clk(clk), .rst(rst), .set(stale_ind), .clr(stale_take), .q(stale_pend)
    );

    always_comb begin
        state_d    = state_q;
        warm_d     = warm_q;
        in_warm_d  = in_warm_q;
        init_d     = init_q;
        t_load     = 1'b0;
        t_val      = '0;
        ref_take   = 1'b0;
        stale_take = 1'b0;
        case (state_q)
            ST_PAUSE: if (t_zero) begin
                state_d = ST_CSR; t_load = 1'b1; t_val = L_CSR;
                warm_d = W_FULL; in_warm_d = 1'b1;
            end
            ST_IDLE: begin
                if (stale_pend) begin
                    state_d = ST_CSR; t_load = 1'b1; t_val = L_CSR;
                    warm_d = W_FULL; in_warm_d = 1'b1; stale_take = 1'b1;
                end else if (sref_req) begin
                    state_d = ST_SR_CSR; t_load = 1'b1; t_val = L_CSR;
                end else if (ref_pend) begin
                    state_d = ST_CSR; t_load = 1'b1; t_val = L_CSR;
                    warm_d = W_ONE; ref_take = 1'b1;
                end
            end
            ST_CSR: if (t_zero) begin
                state_d = ST_RLOW; t_load = 1'b1; t_val = L_LOW;
            end
            ST_RLOW: if (t_zero) begin
                state_d = ST_PRE; t_load = 1'b1; t_val = L_RP;
            end
            ST_PRE: if (t_zero) begin
                if (warm_q > W_ONE) begin
                    state_d = ST_CSR; t_load = 1'b1; t_val = L_CSR;
                    warm_d = warm_q - 1'b1;
                end else begin
                    state_d = ST_IDLE; warm_d = '0;
                    if (in_warm_q) begin
                        init_d = 1'b1; in_warm_d = 1'b0;
                    end
                end
            end
            ST_SR_CSR: if (t_zero) begin
                state_d = ST_SR_HOLD; t_load = 1'b1; t_val = L_RASS;
            end
            ST_SR_HOLD: if (t_zero && !sref_req) begin
                state_d = ST_SR_CHS; t_load = 1'b1; t_val = L_CHS;
            end
            ST_SR_CHS: if (t_zero) begin
                state_d = ST_SR_PRE; t_load = 1'b1; t_val = L_RPS;
            end
            ST_SR_PRE: if (t_zero) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_PAUSE;
            strb_q    <= strobe_of(ST_PAUSE);
            warm_q    <= '0;
            in_warm_q <= 1'b0;
            init_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            strb_q    <= strobe_of(state_d);
            warm_q    <= warm_d;
            in_warm_q <= in_warm_d;
            init_q    <= init_d;
        end
    end

    assign ras_n = strb_q.ras_n;
    assign cas_n = strb_q.cas_n;
    assign busy  = strb_q.busy;
    assign we_n  = 1'b1;
    assign ready = init_q & ~stale_pend & ~in_warm_q;
endmodule

// File: rtl/cbr_refresh_seq_chk.sv
`timescale 1ns/1ps
module cbr_refresh_seq_chk
    import cbr_seq_pkg::*;
#(
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned PAUSE_NS = 200000
) (
    input logic clk,
    input logic rst,
    input logic stale_ind,
    input logic ras_n,
    input logic cas_n,
    input logic ready,
    input logic busy
);
    localparam int unsigned C_PAUSE = ns_to_cyc(PAUSE_NS, CLK_NS);

    int unsigned pcnt;
    always_ff @(posedge clk) begin
        if (rst)                pcnt <= 0;
        else if (pcnt < C_PAUSE) pcnt <= pcnt + 1;
    end

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pcnt < C_PAUSE) |-> (ras_n && cas_n)); // R1
    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> !busy); // R2
    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R3
    AST_CAS_HELD_WITH_RAS: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> ras_n); // R4
    AST_STALE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        stale_ind |=> !ready); // R10
    AST_BUSY_COVERS_STROBES: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n) |-> busy); // R11
endmodule

bind cbr_refresh_seq cbr_refresh_seq_chk #(
    .CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS)
) u_chk (
    .clk(clk), .rst(rst), .stale_ind(stale_ind),
    .ras_n(ras_n), .cas_n(cas_n), .ready(ready), .busy(busy)
);

// File: tb/sim_cbr_refresh_seq.sv
`timescale 1ns/1ps
module sim_cbr_refresh_seq;
    localparam int unsigned CLK  = 8;
    localparam int unsigned PAUSE = 2000, CSR = 10, CHR = 10, RASN = 40, RP = 30;
    localparam int unsigned RASS = 1000, RPS = 85, CHS = 30, WARM = 8;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_PAUSE = cyc_of(PAUSE), E_CSR = cyc_of(CSR), E_CHR = cyc_of(CHR);
    localparam int E_RAS = cyc_of(RASN), E_RP = cyc_of(RP), E_RASS = cyc_of(RASS);
    localparam int E_RPS = cyc_of(RPS), E_CHS = cyc_of(CHS);

    // {pulse count, spacing in cycles, expected refresh cycles}
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{'{1,40,1}, '{3,40,3}, '{2,1,2}, '{3,2,2}, '{4,3,2}, '{2,20,2}};

    logic clk = 1'b0, rst = 1'b1;
    logic refresh_req = 1'b0, sref_req = 1'b0, stale_ind = 1'b0;
    logic ras_n, cas_n, we_n, ready, busy;
    int nchk = 0, nfail = 0;

    always #(CLK/2) clk = ~clk;

    cbr_refresh_seq #(
        .CLK_NS(CLK), .PAUSE_NS(PAUSE), .CSR_NS(CSR), .CHR_NS(CHR), .RAS_NS(RASN),
        .RP_NS(RP), .RASS_NS(RASS), .RPS_NS(RPS), .CHS_NS(CHS), .WARM_CYCLES(WARM)
    ) u0 (
        .clk(clk), .rst(rst), .refresh_req(refresh_req), .sref_req(sref_req),
        .stale_ind(stale_ind), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ready(ready), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe monitor: run lengths in cycles, checked at each strobe edge.
    int ras_lo_run = 0, ras_hi_run = 0, cas_lo_run = 0, both_hi_run = 0, cas_lo_rh_run = 0;
    int ras_falls = 0, cbr_count = 0, sref_count = 0;
    bit last_sref = 0;
    logic p_ras = 1'b1, p_cas = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            ras_lo_run = 0; ras_hi_run = 0; cas_lo_run = 0; both_hi_run = 0;
            cas_lo_rh_run = 0; ras_falls = 0; cbr_count = 0; sref_count = 0;
            last_sref = 0; p_ras = 1'b1; p_cas = 1'b1;
        end else begin
            if (p_ras && !ras_n) begin
                ras_falls++;
                check(!cas_n && cas_lo_run >= E_CSR, "R3 cas lead", cas_lo_run, E_CSR);
                check(we_n === 1'b1, "R12 we_n", we_n, 1);
                check(busy === 1'b1, "R11 busy at ras fall", busy, 1);
                if (last_sref) check(ras_hi_run >= E_RPS, "R8 ras high after exit", ras_hi_run, E_RPS);
            end
            if (p_cas && !cas_n && ras_n && !last_sref && ras_falls > 0)
                check(both_hi_run >= E_RP, "R5 precharge", both_hi_run, E_RP);
            if (!p_ras && ras_n) begin
                if (!cas_n) begin
                    sref_count++; last_sref = 1;
                    check(ras_lo_run >= E_RASS, "R7 sref ras low", ras_lo_run, E_RASS);
                end else begin
                    cbr_count++; last_sref = 0;
                    check(ras_lo_run >= E_RAS && ras_lo_run >= E_CHR, "R4 ras low", ras_lo_run, E_RAS);
                    check(p_cas == 1'b0, "R4 rise together", p_cas, 0);
                end
            end
            if (p_ras && ras_n && !p_cas && cas_n)
                check(cas_lo_rh_run >= E_CHS, "R8 cas hold after exit", cas_lo_rh_run, E_CHS);
            ras_lo_run    = ras_n ? 0 : ras_lo_run + 1;
            ras_hi_run    = ras_n ? ras_hi_run + 1 : 0;
            cas_lo_run    = cas_n ? 0 : cas_lo_run + 1;
            both_hi_run   = (ras_n && cas_n) ? both_hi_run + 1 : 0;
            cas_lo_rh_run = (ras_n && !cas_n) ? cas_lo_rh_run + 1 : 0;
            p_ras = ras_n; p_cas = cas_n;
        end
    end

    task automatic wait_quiet();
        int q = 0;
        while (q < 30) begin
            @(negedge clk);
            if (busy || !ras_n || !cas_n) q = 0; else q++;
        end
    endtask

    task automatic wait_ready(output bit ok);
        int t = 0;
        ok = 0;
        while (t < 5000 && !ok) begin
            @(negedge clk);
            ok = ready;
            t++;
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        bit ok;
        int n, base, base_s;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(ras_n && cas_n, "R1 strobes in reset", {ras_n, cas_n}, 3);
        check(!ready && !busy, "R1 flags in reset", {ready, busy}, 0);
        check(we_n === 1'b1, "R12 we_n in reset", we_n, 1);
        rst = 1'b0;
        n = 0;
        while (ras_n && cas_n && n < 100000) begin
            if (ready) check(0, "R1 ready in pause", 1, 0);
            n++;
            @(negedge clk);
        end
        check(n >= E_PAUSE, "R1 pause length", n, E_PAUSE);
        // R2 warm-up burst
        wait_ready(ok);
        check(ok, "R2 ready after warm-up", ok, 1);
        check(ras_falls == WARM, "R2 warm-up cycles", ras_falls, WARM);
        check(!busy, "R2 busy at ready", busy, 0);
        wait_quiet();
        check(!busy && ras_n && cas_n, "R11 idle flags", {busy, ras_n, cas_n}, 3'b011);

        // R6 refresh request table
        for (int v = 0; v < NV; v++) begin
            base = cbr_count;
            for (int p = 0; p < VEC[v][0]; p++) begin
                refresh_req = 1'b1;
                @(negedge clk);
                refresh_req = 1'b0;
                repeat (VEC[v][1] - 1) @(negedge clk);
            end
            wait_quiet();
            check(cbr_count - base == VEC[v][2], "R6 refresh count", cbr_count - base, VEC[v][2]);
        end

        // R7 long self refresh, held by the request
        base_s = sref_count;
        sref_req = 1'b1;
        repeat (E_RASS + 80) @(negedge clk);
        check(!ras_n && !cas_n, "R7 held while requested", {ras_n, cas_n}, 0);
        sref_req = 1'b0;
        wait_quiet();
        check(sref_count - base_s == 1, "R7 one sref period", sref_count - base_s, 1);

        // R7 short request still gets the minimum hold
        base_s = sref_count;
        sref_req = 1'b1;
        repeat (5) @(negedge clk);
        sref_req = 1'b0;
        repeat (E_CSR + 20) @(negedge clk);
        check(!ras_n, "R7 min hold after early release", ras_n, 0);
        wait_quiet();
        check(sref_count - base_s == 1, "R7 short sref", sref_count - base_s, 1);

        // R9 both requests in the same cycle
        base = cbr_count; base_s = sref_count;
        refresh_req = 1'b1; sref_req = 1'b1;
        @(negedge clk);
        refresh_req = 1'b0;
        repeat (4) @(negedge clk);
        sref_req = 1'b0;
        n = 0;
        while (sref_count == base_s && n < 5000) begin @(negedge clk); n++; end
        check(cbr_count == base, "R9 sref first", cbr_count - base, 0);
        wait_quiet();
        check(cbr_count - base == 1, "R9 refresh after sref", cbr_count - base, 1);

        // R9 a running refresh cycle is not cut short
        base = cbr_count; base_s = sref_count;
        refresh_req = 1'b1;
        @(negedge clk);
        refresh_req = 1'b0;
        @(negedge clk);
        sref_req = 1'b1;
        repeat (20) @(negedge clk);
        sref_req = 1'b0;
        n = 0;
        while (sref_count == base_s && n < 5000) begin @(negedge clk); n++; end
        check(cbr_count - base == 1, "R9 cycle completes first", cbr_count - base, 1);
        wait_quiet();

        // R10 stale indication forces a new warm-up
        check(ready, "R10 ready before stale", ready, 1);
        base = cbr_count;
        stale_ind = 1'b1;
        @(negedge clk);
        stale_ind = 1'b0;
        check(!ready, "R10 ready drops", ready, 0);
        wait_ready(ok);
        check(ok, "R10 ready returns", ok, 1);
        check(cbr_count - base == WARM, "R10 rewarm cycles", cbr_count - base, WARM);
        check(!busy, "R11 idle after rewarm", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule